// File: doc/BRIEF.md
# Dual-Path Clock Root Selector

This block holds the control state of one clock root slice. There are eight candidate sources and two parallel paths, A and B. Each path carries its own source selector and its own pre-divider. A final mux picks one path, and its output feeds a common post-divider and an output gate. Software writes one source-select value. The hardware places that value in the selector of the path that is not driving the output, and then hands the output over to that path. The selectors therefore take turns, A and B.

The block runs in one system clock domain. Each source appears as a one-cycle enable pulse (`src_en`) and a level flag that says whether the source is running (`src_active`). The divided result is a stream of clock-enable pulses. A path's selector changes only after its old source has given a pulse while active. The block then waits for one pulse from the new source before it moves the output. If the old source is stopped, the switch does not complete and the block stays busy. A parameter gives a core variant in which the pre-divider stage is left out.

Top module: `clkroot_sel`

## Requirements
- R1: After reset, both path selectors read 0, the active path reads 0 (path A, where 0 = A and 1 = B), busy reads 0 and the target select reads 0.
- R2: A select write accepted while idle sets the target to the written value and, once the handshake completes, writes it only into the selector of the path that was inactive. The other selector stays unchanged, and selectors never change while the block is idle.
- R3: Writing the same source value twice in a row, each write completing, leaves both selectors at that value.
- R4: A select write made while busy is refused: the target and both selectors keep their values.
- R5: While the inactive path's current source is inactive (`src_active` bit low), that selector does not change, the active path does not flip and busy stays high, however many pulses that source gives.
- R6: The handshake runs in order. First, one pulse from the old source while it is active loads the selector. Then one pulse from the new source flips the active path, and busy falls in that same cycle. A pulse from the new source before the old one has no effect. The active path never changes while the block is idle.
- R7: With the pre-divider present, `clk_en_o` gives one pulse for every (`cfg_pre_m1`+1)×(`cfg_post_m1`+1) pulses of the selected source. Each ratio field holds the ratio minus one, so each ratio runs from 1 to 8.
- R8: In the core variant (HAS_PREDIV=0), `cfg_pre_m1` has no effect and `clk_en_o` gives one pulse for every `cfg_post_m1`+1 source pulses.
- R9: While the gate bit is 0, `clk_en_o` stays low. The divider counters keep running during that time.
- R10: Only pulses from the source named by the active path's selector reach the output. Pulses from any other source produce no `clk_en_o` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_en | input | NSRC | One-cycle enable pulse per source |
| src_active | input | NSRC | Source running flag |
| sel_wr | input | 1 | Target select write strobe |
| sel_val | input | SW | Source value to write |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_gate | input | 1 | Output gate enable (1 = pass) |
| cfg_pre_m1 | input | DIV_W | Pre-divide ratio minus one |
| cfg_post_m1 | input | DIV_W | Post-divide ratio minus one |
| clk_en_o | output | 1 | Divided clock-enable pulse |
| rd_target | output | SW | Last accepted target select |
| rd_sel_a | output | SW | Path A selector |
| rd_sel_b | output | SW | Path B selector |
| rd_path | output | 1 | Active path (0 = A, 1 = B) |
| rd_busy | output | 1 | Switch in progress |

## Verification
The bench goes through eight target writes in a row and checks after every step that the selectors take turns. If the design wrote the active path, or both paths, the modelled A/B pair would no longer match. It stops the old source in the middle of a switch. A design that ignored the active flag would load the selector early and flip the output. The bench also gives new-source pulses before old-source pulses, which catches a handshake that runs out of order. It checks a write made while busy, which must be refused. All 64 pre/post ratio pairs are swept on both variants, so an off-by-one in a counter or a pre-divider left in the core variant changes the number of output pulses.

// File: rtl/clkroot_pkg.sv
package clkroot_pkg;

    typedef enum logic [1:0] {
        SWS_IDLE     = 2'd0,
        SWS_WAIT_OLD = 2'd1,
        SWS_WAIT_NEW = 2'd2
    } sw_state_e;

endpackage

// File: rtl/clkroot_div.sv
module clkroot_div #(
    parameter int DIV_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic [DIV_W-1:0] ratio_m1,
    output logic             hit_o
);
    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        hit_o = tick_i && (cnt_q >= ratio_m1);
        cnt_d = cnt_q;
        if (tick_i) begin
            cnt_d = hit_o ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/clkroot_switch.sv
module clkroot_switch
    import clkroot_pkg::*;
#(
    parameter int NSRC = 8,
    parameter int SW   = $clog2(NSRC)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_en,
    input  logic [NSRC-1:0] src_active,
    input  logic            wr_i,
    input  logic [SW-1:0]   wr_sel,
    output logic [SW-1:0]   target_o,
    output logic [SW-1:0]   sel_a_o,
    output logic [SW-1:0]   sel_b_o,
    output logic            path_o,
    output logic            busy_o
);
    typedef struct packed {
        sw_state_e           st;
        logic [SW-1:0]       target;
        logic [1:0][SW-1:0]  sel;
        logic                path;
    } sw_regs_t;

    sw_regs_t r_d, r_q;
    logic          idle_path;
    logic [SW-1:0] old_src;

    always_comb begin
        r_d       = r_q;
        idle_path = ~r_q.path;
        old_src   = r_q.sel[idle_path];
        unique case (r_q.st)
            SWS_IDLE: begin
                if (wr_i) begin
                    r_d.target = wr_sel;
                    r_d.st     = SWS_WAIT_OLD;
                end
            end
            SWS_WAIT_OLD: begin
                if (src_active[old_src] && src_en[old_src]) begin
                    r_d.sel[idle_path] = r_q.target;
                    r_d.st             = SWS_WAIT_NEW;
                end
            end
            SWS_WAIT_NEW: begin
                if (src_en[r_q.target]) begin
                    r_d.path = idle_path;
                    r_d.st   = SWS_IDLE;
                end
            end
            default: r_d.st = SWS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st     <= SWS_IDLE;
            r_q.target <= '0;
            r_q.sel    <= '0;
            r_q.path   <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign target_o = r_q.target;
    assign sel_a_o  = r_q.sel[0];
    assign sel_b_o  = r_q.sel[1];
    assign path_o   = r_q.path;
    assign busy_o   = (r_q.st != SWS_IDLE);
endmodule

// File: rtl/clkroot_sel.sv
module clkroot_sel #(
    parameter int NSRC       = 8,
    parameter int DIV_W      = 3,
    parameter bit HAS_PREDIV = 1'b1,
    localparam int SW        = $clog2(NSRC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  src_en,
    input  logic [NSRC-1:0]  src_active,
    input  logic             sel_wr,
    input  logic [SW-1:0]    sel_val,
    input  logic             cfg_wr,
    input  logic             cfg_gate,
    input  logic [DIV_W-1:0] cfg_pre_m1,
    input  logic [DIV_W-1:0] cfg_post_m1,
    output logic             clk_en_o,
    output logic [SW-1:0]    rd_target,
    output logic [SW-1:0]    rd_sel_a,
    output logic [SW-1:0]    rd_sel_b,
    output logic             rd_path,
    output logic             rd_busy
);
    typedef struct packed {
        logic             gate;
        logic [DIV_W-1:0] pre_m1;
        logic [DIV_W-1:0] post_m1;
    } cfg_regs_t;

    cfg_regs_t cfg_d, cfg_q;
    logic      gate_on;

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_wr) begin
            cfg_d.gate    = cfg_gate;
            cfg_d.pre_m1  = cfg_pre_m1;
            cfg_d.post_m1 = cfg_post_m1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.gate    <= 1'b1;
            cfg_q.pre_m1  <= '0;
            cfg_q.post_m1 <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign gate_on = cfg_q.gate;

    clkroot_switch #(.NSRC(NSRC), .SW(SW)) u_switch (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_en     (src_en),
        .src_active (src_active),
        .wr_i       (sel_wr),
        .wr_sel     (sel_val),
        .target_o   (rd_target),
        .sel_a_o    (rd_sel_a),
        .sel_b_o    (rd_sel_b),
        .path_o     (rd_path),
        .busy_o     (rd_busy)
    );

    logic [1:0][SW-1:0] path_sel;
    logic [1:0]         path_tick;
    logic [1:0]         path_hit;
    logic               post_hit;

    assign path_sel[0] = rd_sel_a;
    assign path_sel[1] = rd_sel_b;

    for (genvar p = 0; p < 2; p++) begin : g_path
        assign path_tick[p] = src_en[path_sel[p]];
        if (HAS_PREDIV) begin : g_prediv
            clkroot_div #(.DIV_W(DIV_W)) u_pre (
                .clk      (clk),
                .rst_n    (rst_n),
                .tick_i   (path_tick[p]),
                .ratio_m1 (cfg_q.pre_m1),
                .hit_o    (path_hit[p])
            );
        end else begin : g_direct
            assign path_hit[p] = path_tick[p];
        end
    end

    clkroot_div #(.DIV_W(DIV_W)) u_post (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (path_hit[rd_path]),
        .ratio_m1 (cfg_q.post_m1),
        .hit_o    (post_hit)
    );

    assign clk_en_o = gate_on & post_hit;
endmodule

// File: rtl/clkroot_sel_chk.sv
module clkroot_sel_chk #(
    parameter int SW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sel_wr,
    input logic          gate_on,
    input logic          clk_en_o,
    input logic [SW-1:0] rd_target,
    input logic [SW-1:0] rd_sel_a,
    input logic [SW-1:0] rd_sel_b,
    input logic          rd_path,
    input logic          rd_busy
);
    // R2: selectors only move during a switch
    p_sel_hold_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_busy |=> ($stable(rd_sel_a) && $stable(rd_sel_b)));

    // R4: writes during a switch are refused
    p_refuse_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_busy && sel_wr) |=> $stable(rd_target));

    // R6: the active path holds while idle
    p_path_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_busy |=> $stable(rd_path));

    // R6: busy ends exactly when the path flips
    p_busy_end_flip_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_busy) |-> (rd_path != $past(rd_path)));

    // R9: a closed gate blocks every output pulse
    p_gate_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_on |-> !clk_en_o);
endmodule

bind clkroot_sel clkroot_sel_chk #(.SW(SW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_wr    (sel_wr),
    .gate_on   (gate_on),
    .clk_en_o  (clk_en_o),
    .rd_target (rd_target),
    .rd_sel_a  (rd_sel_a),
    .rd_sel_b  (rd_sel_b),
    .rd_path   (rd_path),
    .rd_busy   (rd_busy)
);

// File: tb/test_clkroot_sel.sv
module test_clkroot_sel;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] src_en = '0;
    logic [7:0] src_active = '1;
    logic       sel_wr = 1'b0;
    logic [2:0] sel_val = '0;
    logic       cfg_wr = 1'b0;
    logic       cfg_gate = 1'b1;
    logic [2:0] cfg_pre_m1 = '0;
    logic [2:0] cfg_post_m1 = '0;
    logic       en_main, en_core;
    logic [2:0] rd_target, rd_sel_a, rd_sel_b, c_target, c_sel_a, c_sel_b;
    logic       rd_path, rd_busy, c_path, c_busy;

    int n_checks = 0;
    int n_errors = 0;
    int n_main = 0;
    int n_core = 0;
    logic [2:0] ea = 0, eb = 0;
    logic       ep = 0;

    always #2 clk = ~clk;

    clkroot_sel i_clkroot_sel (
        .clk(clk), .rst_n(rst_n), .src_en(src_en), .src_active(src_active),
        .sel_wr(sel_wr), .sel_val(sel_val), .cfg_wr(cfg_wr), .cfg_gate(cfg_gate),
        .cfg_pre_m1(cfg_pre_m1), .cfg_post_m1(cfg_post_m1), .clk_en_o(en_main),
        .rd_target(rd_target), .rd_sel_a(rd_sel_a), .rd_sel_b(rd_sel_b),
        .rd_path(rd_path), .rd_busy(rd_busy));

    clkroot_sel #(.HAS_PREDIV(1'b0)) i_core (
        .clk(clk), .rst_n(rst_n), .src_en(src_en), .src_active(src_active),
        .sel_wr(sel_wr), .sel_val(sel_val), .cfg_wr(cfg_wr), .cfg_gate(cfg_gate),
        .cfg_pre_m1(cfg_pre_m1), .cfg_post_m1(cfg_post_m1), .clk_en_o(en_core),
        .rd_target(c_target), .rd_sel_a(c_sel_a), .rd_sel_b(c_sel_b),
        .rd_path(c_path), .rd_busy(c_busy));

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick(input logic [7:0] m);
        @(negedge clk);
        src_en = m;
        #1;
        if (en_main) n_main++;
        if (en_core) n_core++;
    endtask

    task automatic settle();
        tick(8'h00);
        tick(8'h00);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        src_en = '0;
        @(negedge clk);
        rst_n = 1'b1;
        ea = 0; eb = 0; ep = 0;
    endtask

    task automatic write_sel(input logic [2:0] s);
        @(negedge clk);
        sel_wr = 1'b1;
        sel_val = s;
        @(negedge clk);
        sel_wr = 1'b0;
        #1;
    endtask

    task automatic write_cfg(input logic g, input logic [2:0] pm, input logic [2:0] qm);
        @(negedge clk);
        cfg_wr = 1'b1;
        cfg_gate = g;
        cfg_pre_m1 = pm;
        cfg_post_m1 = qm;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic check_state(input string req);
        chk({req, " sel_a"}, rd_sel_a, ea);
        chk({req, " sel_b"}, rd_sel_b, eb);
        chk({req, " path"}, rd_path, ep);
    endtask

    task automatic full_switch(input logic [2:0] s);
        logic [2:0] old;
        old = ep ? ea : eb;
        write_sel(s);
        chk("R2 busy after write", rd_busy, 1);
        chk("R2 target", rd_target, s);
        tick(8'h01 << old);
        settle();
        if (ep) ea = s; else eb = s;
        check_state("R6 after old pulse");
        tick(8'h01 << s);
        settle();
        ep = ~ep;
        check_state("R2 after switch");
        chk("R6 busy cleared", rd_busy, 0);
    endtask

    initial begin : watchdog
        #400000;
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        do_reset();
        #1;
        // R1 reset state
        chk("R1 sel_a", rd_sel_a, 0);
        chk("R1 sel_b", rd_sel_b, 0);
        chk("R1 path", rd_path, 0);
        chk("R1 busy", rd_busy, 0);
        chk("R1 target", rd_target, 0);

        // R6 ordering and R4 refusal
        write_sel(3'd3);
        write_sel(3'd5);
        chk("R4 target kept", rd_target, 3);
        tick(8'h08);
        settle();
        check_state("R6 new pulse first ignored");
        chk("R6 still busy", rd_busy, 1);
        tick(8'h01);
        settle();
        eb = 3;
        check_state("R6 old pulse loads");
        chk("R6 busy until new", rd_busy, 1);
        tick(8'h08);
        settle();
        ep = 1;
        check_state("R6 new pulse flips");
        chk("R6 busy low", rd_busy, 0);
        chk("R4 sel unchanged", rd_sel_a, 0);

        // R3 same value twice
        full_switch(3'd3);
        chk("R3 sel_a", rd_sel_a, 3);
        chk("R3 sel_b", rd_sel_b, 3);

        // R5 stopped old source
        src_active[3] = 1'b0;
        write_sel(3'd6);
        for (int i = 0; i < 5; i++) tick(8'h08);
        settle();
        check_state("R5 no change");
        chk("R5 busy held", rd_busy, 1);
        src_active[3] = 1'b1;
        tick(8'h08);
        settle();
        eb = 6;
        tick(8'h40);
        settle();
        ep = 1;
        check_state("R5 recovered");

        // R2 alternation over every source
        for (int s = 0; s < 8; s++) full_switch(3'(7 - s));

        // R10 unselected source ignored (selected on path B is eb)
        n_main = 0;
        for (int s = 0; s < 8; s++)
            if (3'(s) != (ep ? eb : ea)) tick(8'h01 << s);
        settle();
        chk("R10 no output from other sources", n_main, 0);

        // R9 gate masks output
        write_cfg(1'b0, 3'd0, 3'd0);
        n_main = 0;
        for (int i = 0; i < 10; i++) tick(8'h01 << (ep ? eb : ea));
        settle();
        chk("R9 gate closed", n_main, 0);
        write_cfg(1'b1, 3'd0, 3'd0);
        n_main = 0;
        for (int i = 0; i < 10; i++) tick(8'h01 << (ep ? eb : ea));
        settle();
        chk("R9 gate open", n_main, 10);

        // R7 / R8 ratio sweep
        for (int p = 1; p <= 8; p++) begin
            for (int q = 1; q <= 8; q++) begin
                do_reset();
                write_cfg(1'b1, 3'(p - 1), 3'(q - 1));
                n_main = 0;
                n_core = 0;
                for (int k = 0; k < p * q * 3; k++) tick(8'h01);
                settle();
                chk("R7 pre*post ratio", n_main, 3);
                chk("R8 core post-only ratio", n_core, 3 * p);
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule